// File: doc/BRIEF.md
# Deferred Store Commit Buffer

This block sits between the store path of a processor pipeline and the write port of a data cache array. When a store is issued, its word address, data and byte enables are latched into a single holding entry in the same cycle that the cache performs the tag comparison for that store. If the comparison hits, the entry is kept. If it misses, the store is discarded and the miss is reported to the controller one cycle later.

A kept entry is written into the array later, in the first cycle in which no load is reading the array. Two events can force the write earlier. One is a new hit store arriving while the entry is still pending. The other is a flush request. Because of these rules, stores can be issued every cycle without a stall and without an extra write stage in the pipeline.

A load that reads the word held in the pending entry gets the buffered bytes merged over the data read from the array. This means the load never sees stale contents.

Top module: `store_defer_buf`

## Requirements
- R1: After reset the entry is empty (`sb_empty`=1), `arr_wr_en`=0 and `miss_pulse`=0.
- R2: A store with `st_valid`=1 and `tag_hit`=1 is captured at the end of that cycle, and `sb_empty` is 0 in the following cycle.
- R3: A store with `st_valid`=1 and `tag_hit`=0 is not captured. `miss_pulse` is 1 in exactly the next cycle. A pending entry is not replaced by the missed store.
- R4: A pending entry drives `arr_wr_en`=1 in any cycle with `ld_active`=0. In that cycle `arr_wr_addr`, `arr_wr_data` and `arr_wr_be` equal the captured address, data and byte enables.
- R5: While `ld_active`=1, with no hit store and no flush, no array write occurs and the pending entry is kept unchanged.
- R6: A hit store arriving while an entry is pending forces that entry to be written in the same cycle, even when `ld_active`=1. The new store then takes its place.
- R7: Stores issued one per cycle never stall. After a final flush, the number of array writes equals the number of hit stores.
- R8: `ld_rdata` equals `arr_rdata`, except for byte lanes whose enable is set in a pending entry whose address equals `ld_addr`; those lanes take the buffered byte.
- R9: `flush` forces a pending entry to be written in that cycle. If no hit store arrives in the same cycle, `sb_empty` is 1 in the next cycle.
- R10: Byte lane i is data bits [8i+7:8i] and is governed by enable bit i, on both the store and the array write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store issued this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| tag_hit | input | 1 | Tag comparison result for the store this cycle |
| flush | input | 1 | Force out the pending entry |
| ld_active | input | 1 | A load is reading the array this cycle |
| ld_addr | input | AW | Load word address |
| arr_rdata | input | DW | Array read data for the load |
| ld_rdata | output | DW | Load data with buffered bytes merged |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | AW | Array write word address |
| arr_wr_data | output | DW | Array write data |
| arr_wr_be | output | DW/8 | Array write byte enables |
| miss_pulse | output | 1 | One-cycle pulse after a missed store |
| sb_empty | output | 1 | No entry pending |

## Verification
Four stimulus patterns are used:
- A run of back-to-back hit stores with no loads shows that each cycle both commits the previous entry and captures the next.
- Loads held high continuously show the difference between a write held back by loads and a write forced by a new store or a flush.
- Random traffic over a tiny address range, with sparse byte enables, produces frequent forwarding matches. It separates per-lane merging from whole-word replacement and from stale array data.
- Scattered tag misses show that a miss neither disturbs a pending entry nor produces an array write.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    CM_NONE  = 2'd0,
    CM_IDLE  = 2'd1,
    CM_FORCE = 2'd2,
    CM_FLUSH = 2'd3
  } commit_cause_e;
endpackage

// File: rtl/sb_commit_ctl.sv
module sb_commit_ctl
  import sb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic          ld_active,
  input  logic          take_store,
  input  logic          flush,
  output logic          do_commit,
  output commit_cause_e cause
);
  // Priority: a quiet array always wins; otherwise a replacing store, then flush.
  always_comb begin
    cause = CM_NONE;
    if (pending) begin
      if (!ld_active)      cause = CM_IDLE;
      else if (take_store) cause = CM_FORCE;
      else if (flush)      cause = CM_FLUSH;
    end
  end

  assign do_commit = (cause != CM_NONE);

  // R4: a free array cycle is never wasted when an entry waits
  assert_idle_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ld_active) |-> do_commit);
  // R6: a replacing hit store always pushes the old entry out
  assert_force_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && take_store) |-> do_commit);
  // R5: a load-busy cycle with no forcing event writes nothing
  assert_load_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_active && !take_store && !flush) |-> !do_commit);
endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int AW = 10,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          release_e,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          pending,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data,
  output logic [BW-1:0] q_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      q_addr  <= '0;
      q_data  <= '0;
      q_be    <= '0;
    end else begin
      if (capture) begin
        pending <= 1'b1;
        q_addr  <= in_addr;
        q_data  <= in_data;
        q_be    <= in_be;
      end else if (release_e) begin
        pending <= 1'b0;
      end
    end
  end

  // R5: a held entry keeps its contents until it is released or replaced
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !capture && !release_e) |=> (pending && $stable(q_addr) && $stable(q_data) && $stable(q_be)));
  // R2: a capture always leaves an entry pending
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> pending);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int AW = 10,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          pending,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  input  logic [BW-1:0] ent_be,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic          fwd_hit,
  output logic [DW-1:0] ld_rdata
);
  // Expand byte enables to a bit mask; lane i covers bits [8i+7:8i] (R10)
  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < BW; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] base,
                                            input logic [DW-1:0] top,
                                            input logic [DW-1:0] mask);
    return (base & ~mask) | (top & mask);
  endfunction

  assign fwd_hit  = pending && (ent_addr == ld_addr);
  assign ld_rdata = fwd_hit ? overlay(arr_rdata, ent_data, lane_mask(ent_be)) : arr_rdata;

  // R8: without a matching entry the array data passes through untouched
  always_comb begin
    if (!fwd_hit) assert_passthru_R8: assert (ld_rdata == arr_rdata);
  end
endmodule

// File: rtl/store_defer_buf.sv
module store_defer_buf
  import sb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          tag_hit,
  input  logic          flush,
  input  logic          ld_active,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] ld_rdata,
  output logic          arr_wr_en,
  output logic [AW-1:0] arr_wr_addr,
  output logic [DW-1:0] arr_wr_data,
  output logic [BW-1:0] arr_wr_be,
  output logic          miss_pulse,
  output logic          sb_empty
);
  // Named internal events
  logic          ev_take;
  logic          ev_miss;
  logic          ev_commit;
  logic          ev_fwd;
  commit_cause_e ev_cause;
  logic          pend;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;
  logic [BW-1:0] e_be;

  assign ev_take = st_valid && tag_hit;
  assign ev_miss = st_valid && !tag_hit;

  sb_commit_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pend),
    .ld_active  (ld_active),
    .take_store (ev_take),
    .flush      (flush),
    .do_commit  (ev_commit),
    .cause      (ev_cause)
  );

  sb_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ev_take),
    .release_e (ev_commit),
    .in_addr   (st_addr),
    .in_data   (st_data),
    .in_be     (st_be),
    .pending   (pend),
    .q_addr    (e_addr),
    .q_data    (e_data),
    .q_be      (e_be)
  );

  sb_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .pending   (pend),
    .ent_addr  (e_addr),
    .ent_data  (e_data),
    .ent_be    (e_be),
    .ld_addr   (ld_addr),
    .arr_rdata (arr_rdata),
    .fwd_hit   (ev_fwd),
    .ld_rdata  (ld_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_pulse <= 1'b0;
    else        miss_pulse <= ev_miss;
  end

  assign arr_wr_en   = ev_commit;
  assign arr_wr_addr = e_addr;
  assign arr_wr_data = e_data;
  assign arr_wr_be   = e_be;
  assign sb_empty    = !pend;

  // R3: a missed store is reported in the next cycle
  assert_miss_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> miss_pulse);
  // R3: a miss alone never empties or fills the entry
  assert_miss_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !ev_commit) |=> (sb_empty == $past(sb_empty)));
  // R9: flush without a new store leaves the buffer empty
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !ev_take) |=> sb_empty);
  // R1: no write can come out of an empty buffer
  assert_no_ghost_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> !arr_wr_en);
  // R6: the cause reported for a load-cycle write is a forcing event
  assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && ld_active) |-> (ev_cause == CM_FORCE || ev_cause == CM_FLUSH));
  // R8: forwarding only when a load address meets a live entry
  assert_fwd_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd |-> !sb_empty);
endmodule

// File: tb/tb_store_defer_buf.sv
module tb_store_defer_buf;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic          tag_hit = 1'b0;
  logic          flush = 1'b0;
  logic          ld_active = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] arr_rdata = '0;
  logic [DW-1:0] ld_rdata;
  logic          arr_wr_en;
  logic [AW-1:0] arr_wr_addr;
  logic [DW-1:0] arr_wr_data;
  logic [BW-1:0] arr_wr_be;
  logic          miss_pulse;
  logic          sb_empty;

  always #5 clk = ~clk;

  store_defer_buf #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .tag_hit(tag_hit), .flush(flush),
    .ld_active(ld_active), .ld_addr(ld_addr), .arr_rdata(arr_rdata),
    .ld_rdata(ld_rdata), .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr),
    .arr_wr_data(arr_wr_data), .arr_wr_be(arr_wr_be),
    .miss_pulse(miss_pulse), .sb_empty(sb_empty)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_hits = 0;
  int n_writes = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model state
  bit            m_pend = 0;
  bit [AW-1:0]   m_addr = '0;
  bit [DW-1:0]   m_data = '0;
  bit [BW-1:0]   m_be = '0;
  bit            m_miss = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit model_commit();
    return m_pend && (!ld_active || (st_valid && tag_hit) || flush);
  endfunction

  task automatic compare();
    bit            c;
    logic [DW-1:0] exp_ld;
    string         tg;
    c = model_commit();
    if (!m_pend)                       tg = "R1";
    else if (!ld_active)               tg = "R4";
    else if (st_valid && tag_hit)      tg = "R6";
    else if (flush)                    tg = "R9";
    else                               tg = "R5";
    check(arr_wr_en === c, tg, "wr_en", {31'b0, arr_wr_en}, {31'b0, c});
    if (c) begin
      check(arr_wr_addr === m_addr, tg, "wr_addr", DW'(arr_wr_addr), DW'(m_addr));
      check(arr_wr_data === m_data, tg, "wr_data", arr_wr_data, m_data);
      check(arr_wr_be === m_be, "R10", "wr_be", DW'(arr_wr_be), DW'(m_be));
    end
    // R8: byte-wise merge computed lane by lane
    exp_ld = arr_rdata;
    if (m_pend && m_addr == ld_addr)
      for (int i = 0; i < BW; i++)
        if (m_be[i]) exp_ld[8*i +: 8] = m_data[8*i +: 8];
    check(ld_rdata === exp_ld, "R8", "ld_rdata", ld_rdata, exp_ld);
    check(sb_empty === !m_pend, "R2", "empty", {31'b0, sb_empty}, {31'b0, !m_pend});
    check(miss_pulse === m_miss, "R3", "miss", {31'b0, miss_pulse}, {31'b0, m_miss});
  endtask

  task automatic update();
    bit c;
    c = model_commit();
    if (c) n_writes++;
    m_miss = st_valid && !tag_hit;
    if (st_valid && tag_hit) begin
      n_hits++;
      m_pend = 1; m_addr = st_addr; m_data = st_data; m_be = st_be;
    end else if (c) begin
      m_pend = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    @(posedge clk);
    update();
    cyc++;
    #1;
  endtask

  task automatic idle_in();
    st_valid = 0; tag_hit = 0; flush = 0; ld_active = 0;
  endtask

  task automatic put_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BW-1:0] be, input bit hit);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; tag_hit = hit;
  endtask

  task automatic rand_cycle(input int ld_pct, input int st_pct, input int miss_pct,
                            input int amask);
    st_valid  = ($urandom_range(99) < st_pct);
    tag_hit   = ($urandom_range(99) >= miss_pct);
    st_addr   = AW'($urandom) & AW'(amask);
    st_data   = $urandom;
    st_be     = BW'($urandom);
    ld_active = ($urandom_range(99) < ld_pct);
    ld_addr   = AW'($urandom) & AW'(amask);
    arr_rdata = $urandom;
    flush     = ($urandom_range(99) < 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk);
    check(sb_empty === 1'b1, "R1", "reset empty", {31'b0, sb_empty}, 32'd1);
    check(arr_wr_en === 1'b0, "R1", "reset wr_en", {31'b0, arr_wr_en}, 32'd0);
    check(miss_pulse === 1'b0, "R1", "reset miss", {31'b0, miss_pulse}, 32'd0);
    @(posedge clk); #1;

    // R10: one-lane store, then load of that word under continuous loads
    put_store(10'h12, 32'hAABBCCDD, 4'b0010, 1); step();
    idle_in(); ld_active = 1; ld_addr = 10'h12; arr_rdata = 32'h11223344;
    @(negedge clk);
    check(ld_rdata === 32'h1122CC44, "R10", "lane1 merge", ld_rdata, 32'h1122CC44);
    @(posedge clk); update(); cyc++; #1;
    // R5: load held, entry waits; then R3 miss while pending
    step();
    put_store(10'h20, 32'h0, 4'hF, 0); step();
    idle_in(); ld_active = 1; step();
    // R9: flush under load
    flush = 1; step();
    idle_in(); step();

    // Pattern A: back-to-back hit stores, no loads (R7)
    for (int k = 0; k < 40; k++) begin
      put_store(AW'(k), $urandom, BW'($urandom), 1); step();
    end
    idle_in(); step();
    // Pattern B: loads always on, stores replace (R6)
    for (int k = 0; k < 200; k++) begin
      rand_cycle(100, 60, 10, 3); flush = 0; step();
    end
    // Pattern C: mixed traffic over a tiny address range (R8)
    for (int k = 0; k < 3000; k++) begin
      rand_cycle(50, 50, 20, 1); step();
    end
    // Pattern D: sparse misses over wide addresses
    for (int k = 0; k < 1000; k++) begin
      rand_cycle(70, 40, 30, 1023); step();
    end
    idle_in(); ld_active = 1; flush = 1; step();
    idle_in(); step();
    // R7: every hit store reached the array
    check(n_writes == n_hits, "R7", "write count", DW'(n_writes), DW'(n_hits));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule